// File: doc/BRIEF.md
# Serial Bit-Stuffing NRZI Transmitter

This block is the transmit half of a low-level serial bus controller. It pulls packet bytes from an upstream buffer over a valid/ready handshake and turns them into one bit stream, least significant bit first. It inserts a forced zero after every run of six ones and drives the result onto a single line as an NRZI level, together with an output-enable for the transceiver. A separate bit-rate strobe paces the stream: each strobe taken while the packet is active puts exactly one bit, data or stuffed, on the line.

A packet starts when the transmit-enable input rises while the block is idle and the length input is non-zero. Lowering transmit-enable in the middle of a packet freezes everything in place, and raising it again resumes where the packet stopped. A byte counter tracks how many bytes have left the shifter. A one-cycle done pulse marks the bit period after the final bit, and the line returns to its idle level at the same moment. Any check sequence is supplied by upstream logic as ordinary payload bytes.

Top module: `usbtx_datapath`

## Requirements
- R1: After reset, line_out is 1, line_oe is 0, byte_ready is 0, pkt_done is 0 and bytes_sent is 0.
- R2: A packet starts only on a 0-to-1 change of tx_en while idle. line_oe is 1 from the next cycle until the packet ends, and a tx_en that stays high after a packet does not start another.
- R3: Each byte is sent bit 0 first through bit 7. Exactly one bit is emitted per bit_stb cycle while tx_en is high and the packet is active.
- R4: After six consecutive emitted ones, the next emitted bit is a stuffed 0. The run counts across byte boundaries, applies after the final data bit, restarts on every emitted 0, and restarts at the start of each packet.
- R5: An emitted 1 leaves line_out unchanged and an emitted 0 (data or stuffed) inverts it. line_out is 1 before the first bit of a packet.
- R6: While a stuffed bit is pending, byte_ready is 0 and the shifter keeps its contents.
- R7: While tx_en is low during a packet, bit_stb has no effect: line_out, line_oe and bytes_sent hold and byte_ready is 0.
- R8: bytes_sent is cleared at packet start, rises by one each time the last bit of a byte is emitted, and equals the effective length when the packet ends.
- R9: The effective length is pkt_len clamped to 512 bytes. A pkt_len of 0 starts nothing.
- R10: On the first bit_stb with tx_en high after the final bit (including any trailing stuffed bit), pkt_done pulses for one cycle, line_oe drops to 0 and line_out returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable: rising edge starts, low pauses |
| bit_stb | input | 1 | One-cycle bit-rate strobe |
| pkt_len | input | 10 | Packet length in bytes, sampled at start |
| byte_data | input | 8 | Next payload byte |
| byte_valid | input | 1 | byte_data is valid |
| byte_ready | output | 1 | Shifter can accept a byte |
| line_out | output | 1 | NRZI line level |
| line_oe | output | 1 | Line driver enable |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| bytes_sent | output | 10 | Bytes fully serialized in the current or last packet |

## Verification
A wrong run-of-ones count shows up as a missing or extra level inversion on line_out within one strobe of the sixth one. This appears as a line sequence that differs from a bench-computed NRZI stream, so every packet is compared level by level. A shifter that moves during a stuff bit, or a ready that rises too early, corrupts the following byte by a one-bit skew, and this becomes visible within eight strobes. A byte counter that is off ends the packet a whole byte early or late, so the done pulse, bytes_sent and the total bit count all disagree at the end. Pauses, trailing stuff, zero and oversized lengths, and back-to-back packets that must clear the run counter are each driven on purpose.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_RUN   = 2'd1,
        TX_FLUSH = 2'd2
    } tx_state_e;
endpackage

// File: rtl/usbtx_shifter.sv
module usbtx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              shift_i,
    input  logic              hold_i,
    output logic              full_o,
    output logic              bit_o,
    output logic              last_o
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic              full;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.data = byte_i;
            s_d.idx  = '0;
            s_d.full = 1'b1;
        end else if (shift_i) begin
            s_d.data = s_q.data >> 1;
            s_d.idx  = s_q.idx + IDX_W'(1);
            if (s_q.idx == IDX_W'(BYTE_W - 1)) begin
                s_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full_o = s_q.full;
    assign bit_o  = s_q.data[0];
    assign last_o = (s_q.idx == IDX_W'(BYTE_W - 1));

    // R6: a pending stuffed bit freezes the shift register
    a_r6_hold_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(s_q.data) && $stable(s_q.idx));

    a_r3_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> !load_i);
endmodule

// File: rtl/usbtx_stuffer.sv
module usbtx_stuffer #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic emit_i,
    input  logic bit_i,
    output logic stuff_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] ones;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.ones = '0;
        end else if (emit_i) begin
            s_d.ones = bit_i ? s_q.ones + RUN_W'(1) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stuff_o = (s_q.ones == RUN_W'(RUN_LEN));

    // R4: the run never exceeds the stuffing limit
    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ones <= RUN_W'(RUN_LEN));

    // R4: while a stuff is pending, the emitted bit is a zero
    a_r4_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_o && emit_i) |-> !bit_i);
endmodule

// File: rtl/usbtx_nrzi.sv
module usbtx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic emit_i,
    input  logic bit_i,
    output logic line_o
);
    typedef struct packed {
        logic level;
    } nz_t;

    nz_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (idle_i) begin
            s_d.level = 1'b1;
        end else if (emit_i && !bit_i) begin
            s_d.level = ~s_q.level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.level <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.level;

    // R5: an emitted one keeps the level
    a_r5_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && bit_i && !idle_i) |=> $stable(line_o));

    // R5: an emitted zero inverts the level
    a_r5_zero_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && !bit_i && !idle_i) |=> (line_o != $past(line_o)));
endmodule

// File: rtl/usbtx_datapath.sv
module usbtx_datapath #(
    parameter int BYTE_W    = 8,
    parameter int RUN_LEN   = 6,
    parameter int MAX_BYTES = 512,
    parameter int LEN_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_stb,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    output logic              byte_ready,
    output logic              line_out,
    output logic              line_oe,
    output logic              pkt_done,
    output logic [LEN_W-1:0]  bytes_sent
);
    import usbtx_pkg::*;

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BYTES);

    typedef struct packed {
        tx_state_e        st;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             en_prev;
        logic             oe;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic sh_full, sh_bit, sh_last;
    logic stuff_pend;
    logic go, start, emit_stuff, emit_data, finish, emit, emit_bit, byte_end, load;

    always_comb begin
        go         = bit_stb && tx_en;
        start      = (c_q.st == TX_IDLE) && tx_en && !c_q.en_prev && (pkt_len != '0);
        emit_stuff = go && (c_q.st != TX_IDLE) && stuff_pend;
        emit_data  = go && (c_q.st == TX_RUN) && !stuff_pend && sh_full;
        finish     = go && (c_q.st == TX_FLUSH) && !stuff_pend;
        emit       = emit_stuff || emit_data;
        emit_bit   = emit_data ? sh_bit : 1'b0;
        byte_end   = emit_data && sh_last;
        byte_ready = (c_q.st == TX_RUN) && tx_en && !sh_full && !stuff_pend;
        load       = byte_valid && byte_ready;

        c_d         = c_q;
        c_d.en_prev = tx_en;
        c_d.done    = 1'b0;
        if (start) begin
            c_d.st  = TX_RUN;
            c_d.len = (pkt_len > LEN_CAP) ? LEN_CAP : pkt_len;
            c_d.cnt = '0;
            c_d.oe  = 1'b1;
        end else if (finish) begin
            c_d.st   = TX_IDLE;
            c_d.oe   = 1'b0;
            c_d.done = 1'b1;
        end else if (byte_end) begin
            c_d.cnt = c_q.cnt + LEN_W'(1);
            if (c_q.cnt + LEN_W'(1) == c_q.len) begin
                c_d.st = TX_FLUSH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: TX_IDLE, len: '0, cnt: '0, en_prev: 1'b0, oe: 1'b0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    usbtx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .byte_i  (byte_data),
        .shift_i (emit_data),
        .hold_i  (stuff_pend && (c_q.st == TX_RUN)),
        .full_o  (sh_full),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    usbtx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start),
        .emit_i  (emit),
        .bit_i   (emit_bit),
        .stuff_o (stuff_pend)
    );

    usbtx_nrzi u_nrzi (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (start || finish),
        .emit_i (emit),
        .bit_i  (emit_bit),
        .line_o (line_out)
    );

    assign line_oe    = c_q.oe;
    assign pkt_done   = c_q.done;
    assign bytes_sent = c_q.cnt;

    // R6: no byte is accepted while a stuffed bit waits
    a_r6_no_ready_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_pend |-> !byte_ready);

    // R7: with tx_en low the line side is frozen
    a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> $stable(line_out) && $stable(line_oe) && $stable(bytes_sent));

    // R9: the byte count never passes the cap
    a_r9_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_sent <= LEN_CAP);

    // R10: the done pulse follows an enabled strobe and leaves the line idle
    a_r10_done_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(bit_stb && tx_en) && line_out && !line_oe);

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);
endmodule

// File: tb/usbtx_datapath_test.sv
module usbtx_datapath_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       bit_stb = 1'b0;
    logic [9:0] pkt_len = '0;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic       byte_ready, line_out, line_oe, pkt_done;
    logic [9:0] bytes_sent;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usbtx_datapath uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_stb(bit_stb),
        .pkt_len(pkt_len), .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .line_out(line_out), .line_oe(line_oe),
        .pkt_done(pkt_done), .bytes_sent(bytes_sent)
    );

    logic [7:0] mem [0:599];
    int  feed_idx = 0;
    int  feed_n = 0;
    logic feed_rst = 1'b0;

    assign byte_valid = (feed_idx < feed_n);
    assign byte_data  = (feed_idx < 600) ? mem[feed_idx] : 8'h00;

    always @(posedge clk) begin
        if (feed_rst) feed_idx <= 0;
        else if (byte_valid && byte_ready) feed_idx <= feed_idx + 1;
    end

    logic exp_lvl [0:5999];
    logic exp_stf [0:5999];
    logic got_lvl [0:5999];

    // len(10) base(8) step(8) expected bytes_sent(10)
    localparam logic [35:0] VEC [0:6] = '{
        {10'd1, 8'h00, 8'h00, 10'd1},
        {10'd1, 8'hFC, 8'h00, 10'd1},
        {10'd1, 8'hFF, 8'h00, 10'd1},
        {10'd2, 8'hFF, 8'h00, 10'd2},
        {10'd4, 8'h3F, 8'h01, 10'd4},
        {10'd9, 8'hA5, 8'h11, 10'd9},
        {10'd3, 8'h7E, 8'h81, 10'd3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
    end

    task automatic run_pkt(input int len, input logic [7:0] base, input logic [7:0] step,
                           input int pause_at, input int exp_sent);
        int eff, nexp, k, ones, first_bad;
        logic lvl, rdy_bad, fin, pause_bad;
        eff = (len > 512) ? 512 : len;
        for (int i = 0; i < eff; i++) mem[i] = 8'(base + 8'(step * i));
        nexp = 0; ones = 0; lvl = 1'b1;
        for (int i = 0; i < eff; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) ones++; else begin ones = 0; lvl = ~lvl; end
                exp_lvl[nexp] = lvl; exp_stf[nexp] = 1'b0; nexp++;
                if (ones == 6) begin
                    ones = 0; lvl = ~lvl;
                    exp_lvl[nexp] = lvl; exp_stf[nexp] = 1'b1; nexp++;
                end
            end
        end
        @(negedge clk) feed_rst = 1'b1;
        @(negedge clk) begin feed_rst = 1'b0; feed_n = eff; pkt_len = 10'(len); tx_en = 1'b1; end
        @(negedge clk);
        @(negedge clk);
        chk(line_oe && line_out, "R2", "oe/level after start", {line_oe, line_out}, 3);
        k = 0; fin = 1'b0; rdy_bad = 1'b0; pause_bad = 1'b0;
        while (!fin && k < 6000) begin
            repeat (2) begin
                @(negedge clk);
                if (k < nexp && exp_stf[k] && byte_ready) rdy_bad = 1'b1;
            end
            bit_stb = 1'b1;
            @(negedge clk) bit_stb = 1'b0;
            if (pkt_done) fin = 1'b1;
            else if (line_oe) begin got_lvl[k] = line_out; k++; end
            if (pause_at > 0 && k == pause_at && !fin) begin
                logic hl; logic [9:0] hc;
                hl = line_out; hc = bytes_sent;
                tx_en = 1'b0;
                repeat (6) begin
                    @(negedge clk) bit_stb = 1'b1;
                    @(negedge clk) bit_stb = 1'b0;
                    if (line_out != hl || !line_oe || byte_ready || bytes_sent != hc) pause_bad = 1'b1;
                end
                chk(!pause_bad, "R7", "line/oe/ready/count held during pause", pause_bad, 0);
                tx_en = 1'b1;
            end
        end
        first_bad = -1;
        for (int i = 0; i < nexp && i < k; i++)
            if (first_bad < 0 && got_lvl[i] != exp_lvl[i]) first_bad = i;
        chk(k == nexp, "R4", "emitted bit count", k, nexp);
        chk(first_bad < 0, "R3 R5", "first mismatching line bit index", first_bad, -1);
        chk(fin && !line_oe && line_out, "R10", "done with idle line", {fin, line_oe, line_out}, 5);
        chk(bytes_sent == 10'(exp_sent), "R8", "bytes_sent at end", bytes_sent, exp_sent);
        chk(!rdy_bad, "R6", "ready low while stuff pending", rdy_bad, 0);
        @(negedge clk);
        chk(!pkt_done, "R10", "done lasts one cycle", pkt_done, 0);
        repeat (2) @(negedge clk);
        chk(!line_oe, "R2", "no restart while tx_en stays high", line_oe, 0);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 600; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_out && !line_oe && !byte_ready && !pkt_done && bytes_sent == 0,
            "R1", "reset outputs", {line_out, line_oe, byte_ready, pkt_done}, 8);

        // table walk; entries 2 then 3 need the run counter cleared at start (R4)
        for (int v = 0; v < 7; v++)
            run_pkt(int'(VEC[v][35:26]), VEC[v][25:18], VEC[v][17:10], 0, int'(VEC[v][9:0]));

        // R9: zero length never starts
        @(negedge clk) begin pkt_len = 10'd0; tx_en = 1'b1; end
        begin
            logic seen;
            seen = 1'b0;
            repeat (4) begin
                @(negedge clk) bit_stb = 1'b1;
                @(negedge clk) bit_stb = 1'b0;
                if (line_oe || byte_ready || pkt_done || !line_out) seen = 1'b1;
            end
            chk(!seen, "R9", "zero length stays idle", seen, 0);
        end
        @(negedge clk) tx_en = 1'b0;

        // R7: pause mid-packet with stuffing in flight
        run_pkt(4, 8'hFF, 8'h00, 5, 4);

        // R9: oversize length clamps to 512
        run_pkt(600, 8'hFF, 8'h00, 0, 512);

        summary();
    end
endmodule